// File: doc/BRIEF.md
# Bus Trigger Arming Controller

This block decides when a trigger arriving over the instrument bus may move a supply's outputs to new levels. Software first loads pending voltage and current setpoints. It then arms the trigger, either for a single shot or in a continuous mode that rearms after every trigger. A bus trigger is acted on only if every gating condition is true at once: the block is armed, the trigger source is set to the bus, the output is on, and the device is currently addressed as a listener. A trigger that fails any of these conditions is discarded without a trace.

When a trigger is accepted, both pending setpoints are copied into the active setpoint registers. A one-clock applied pulse appears in the same cycle as the new active values. The waiting flag shows that the block is armed, and it falls when a single-shot trigger is used up. An abort pulse disarms the block. Continuous mode rearms it again one cycle after an abort.

Top module: `bus_trigger_arm`

## Requirements
- R1: After reset, `waiting` and `trigApplied` are 0, and `activeVolt` and `activeCurr` are 0.
- R2: A `wrVolt` or `wrCurr` pulse stores `wrData` as the pending voltage or pending current value. Storing a pending value does not change the active setpoints.
- R3: A trigger is accepted in a cycle only when `busTrig`, `waiting`, `srcIsBus`, `outputOn` and `listenerAddr` are all 1 and `abortReq` is 0. In any other case the active setpoints and `trigApplied` do not change, and no error output exists.
- R4: An accepted trigger loads the pending values into the active setpoints at the next clock edge. `trigApplied` is 1 for exactly that following cycle, which is the same cycle in which the new active values first appear.
- R5: With `contMode` at 0, an `armOnce` pulse sets `waiting` in the next cycle. An accepted trigger with no arm pulse in the same cycle clears `waiting` in the next cycle, so later triggers are dropped.
- R6: While `contMode` is 1 and `abortReq` is 0, `waiting` is 1 in the next cycle, including the cycle after an accepted trigger.
- R7: `abortReq` clears `waiting` in the next cycle and overrides both `armOnce` and `contMode`. If `contMode` stays 1, `waiting` returns to 1 one cycle later.
- R8: If `armOnce` and an accepted trigger occur in the same cycle, the trigger is applied and `waiting` stays 1.
- R9: If a pending write and an accepted trigger occur in the same cycle, the trigger applies the pending value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armOnce | input | 1 | Pulse that arms the block for a single trigger |
| abortReq | input | 1 | Pulse that disarms the block |
| busTrig | input | 1 | Pulse for a trigger received over the bus |
| wrVolt | input | 1 | Write strobe for the pending voltage |
| wrCurr | input | 1 | Write strobe for the pending current |
| wrData | input | 16 | Data for a pending setpoint write |
| contMode | input | 1 | Level input: continuous rearm mode |
| srcIsBus | input | 1 | Level input: trigger source is the bus |
| outputOn | input | 1 | Level input: output enabled |
| listenerAddr | input | 1 | Level input: device addressed as listener |
| waiting | output | 1 | Armed and waiting for a trigger |
| trigApplied | output | 1 | One-cycle pulse when new setpoints take effect |
| activeVolt | output | 16 | Active voltage setpoint |
| activeCurr | output | 16 | Active current setpoint |

## Verification
The arm state is visible directly on `waiting`. Any error in that state therefore shows up one cycle after the stimulus that caused it. A wrongly kept or lost arm state also shows up later, when the next bus trigger is applied or dropped against expectation, and both `trigApplied` and the active setpoints reveal it. An error in a gating term appears only when that one condition is low while all the others are high. For this reason the bench sweeps every combination of the gates together with the arm state and the abort input. Setpoint ordering errors appear as the wrong value on the active outputs in the cycle that `trigApplied` is high.

// File: rtl/trig_arm_pkg.sv
package trig_arm_pkg;
  parameter int SP_WIDTH = 16;
  parameter int NUM_CH = 2;

  typedef struct packed {
    logic apply;
    logic capCurr;
    logic capVolt;
  } trigStrobe_t;
endpackage

// File: rtl/trig_arm_ctrl.sv
module trig_arm_ctrl
  import trig_arm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armOnce,
  input  logic        abortReq,
  input  logic        busTrig,
  input  logic        wrVolt,
  input  logic        wrCurr,
  input  logic        contMode,
  input  logic        srcIsBus,
  input  logic        outputOn,
  input  logic        listenerAddr,
  output logic        waiting,
  output trigStrobe_t strb
);
  logic gatesOpen;
  logic fire;
  logic waitingNext;

  assign gatesOpen = srcIsBus & outputOn & listenerAddr;
  assign fire      = busTrig & waiting & gatesOpen & ~abortReq;

  always_comb begin
    if (abortReq)                 waitingNext = 1'b0;
    else if (contMode || armOnce) waitingNext = 1'b1;
    else if (fire)                waitingNext = 1'b0;
    else                          waitingNext = waiting;
  end

  always_ff @(posedge clk) begin
    if (!rstN) waiting <= 1'b0;
    else       waiting <= waitingNext;
  end

  assign strb.apply   = fire;
  assign strb.capVolt = wrVolt;
  assign strb.capCurr = wrCurr;

  // R7: abort always disarms in the next cycle
  p_abort_disarms_r7: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !waiting);
  // R6: continuous mode keeps the block armed
  p_cont_rearm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (contMode && !abortReq) |=> waiting);
  // R5: a single-shot trigger consumes the arm
  p_single_consume_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.apply && !contMode && !armOnce) |=> !waiting);
  // R3: nothing is applied while disarmed
  p_no_apply_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !waiting |-> !strb.apply);
endmodule

// File: rtl/trig_setpoint_path.sv
module trig_setpoint_path
  import trig_arm_pkg::*;
#(
  parameter int W = SP_WIDTH,
  parameter int NCH = NUM_CH
) (
  input  logic         clk,
  input  logic         rstN,
  input  trigStrobe_t  strb,
  input  logic [W-1:0] wrData,
  output logic         trigApplied,
  output logic [W-1:0] activeVolt,
  output logic [W-1:0] activeCurr
);
  logic [NCH-1:0] capVec;
  logic [W-1:0]   pendReg [NCH];
  logic [W-1:0]   actReg  [NCH];

  assign capVec = NCH'({strb.capCurr, strb.capVolt});

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendReg[ch] <= '0;
        actReg[ch]  <= '0;
      end else begin
        if (strb.apply) actReg[ch]  <= pendReg[ch];
        if (capVec[ch]) pendReg[ch] <= wrData;
      end
    end

    // R2: active setpoints move only on an applied trigger
    p_hold_active_r2: assert property (@(posedge clk) disable iff (!rstN)
      !strb.apply |=> $stable(actReg[ch]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) trigApplied <= 1'b0;
    else       trigApplied <= strb.apply;
  end

  assign activeVolt = actReg[0];
  assign activeCurr = actReg[1];

  // R4 / R9: applied values are the pending values from before the edge
  p_apply_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.apply |=> (trigApplied && activeVolt == $past(pendReg[0])
                    && activeCurr == $past(pendReg[1])));
endmodule

// File: rtl/bus_trigger_arm.sv
module bus_trigger_arm
  import trig_arm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                armOnce,
  input  logic                abortReq,
  input  logic                busTrig,
  input  logic                wrVolt,
  input  logic                wrCurr,
  input  logic [SP_WIDTH-1:0] wrData,
  input  logic                contMode,
  input  logic                srcIsBus,
  input  logic                outputOn,
  input  logic                listenerAddr,
  output logic                waiting,
  output logic                trigApplied,
  output logic [SP_WIDTH-1:0] activeVolt,
  output logic [SP_WIDTH-1:0] activeCurr
);
  trigStrobe_t strb;

  trig_arm_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .armOnce(armOnce), .abortReq(abortReq),
    .busTrig(busTrig), .wrVolt(wrVolt), .wrCurr(wrCurr),
    .contMode(contMode), .srcIsBus(srcIsBus), .outputOn(outputOn),
    .listenerAddr(listenerAddr), .waiting(waiting), .strb(strb)
  );

  trig_setpoint_path #(.W(SP_WIDTH), .NCH(NUM_CH)) i_path (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .trigApplied(trigApplied), .activeVolt(activeVolt), .activeCurr(activeCurr)
  );

  // R4: the applied pulse never lasts two cycles without a new trigger
  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    (trigApplied && !$past(strb.apply, 1)) |-> 1'b0);
endmodule

// File: tb/test_bus_trigger_arm.sv
`timescale 1ns/1ps
module test_bus_trigger_arm;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armOnce = 0, abortReq = 0, busTrig = 0, wrVolt = 0, wrCurr = 0;
  logic [15:0] wrData = '0;
  logic contMode = 0, srcIsBus = 0, outputOn = 0, listenerAddr = 0;
  logic waiting, trigApplied;
  logic [15:0] activeVolt, activeCurr;

  int nChecks = 0;
  int nFails = 0;

  logic mWait = 0, mPulse = 0;
  logic [15:0] mPendV = 0, mPendC = 0, mActV = 0, mActC = 0;

  always #4 clk = ~clk;

  bus_trigger_arm i_bus_trigger_arm (
    .clk(clk), .rstN(rstN), .armOnce(armOnce), .abortReq(abortReq),
    .busTrig(busTrig), .wrVolt(wrVolt), .wrCurr(wrCurr), .wrData(wrData),
    .contMode(contMode), .srcIsBus(srcIsBus), .outputOn(outputOn),
    .listenerAddr(listenerAddr), .waiting(waiting), .trigApplied(trigApplied),
    .activeVolt(activeVolt), .activeCurr(activeCurr)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "waiting", 16'(waiting), 16'(mWait));
    chk(tag, "trigApplied", 16'(trigApplied), 16'(mPulse));
    chk(tag, "activeVolt", activeVolt, mActV);
    chk(tag, "activeCurr", activeCurr, mActC);
  endtask

  // Drives one cycle at a negedge, predicts from the requirements, compares at the next negedge
  task automatic step(input logic a, input logic ab, input logic bt, input logic wv,
                      input logic wc, input logic [15:0] d, input string tag);
    logic fire, nWait;
    armOnce = a; abortReq = ab; busTrig = bt; wrVolt = wv; wrCurr = wc; wrData = d;
    fire = bt & mWait & srcIsBus & outputOn & listenerAddr & ~ab;
    if (ab) nWait = 0;
    else if (contMode | a) nWait = 1;
    else if (fire) nWait = 0;
    else nWait = mWait;
    @(posedge clk);
    @(negedge clk);
    if (fire) begin mActV = mPendV; mActC = mPendC; end
    if (wv) mPendV = d;
    if (wc) mPendC = d;
    mWait = nWait;
    mPulse = fire;
    armOnce = 0; abortReq = 0; busTrig = 0; wrVolt = 0; wrCurr = 0;
    compareAll(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 16'h0, tag);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareAll("R1");

    // R2: pending writes alone leave the actives untouched
    step(0, 0, 0, 1, 0, 16'h1234, "R2");
    step(0, 0, 0, 0, 1, 16'h00ab, "R2");
    idle("R2");

    // R3/R4/R5/R7: sweep arm state, every gate, abort and trigger
    for (int i = 0; i < 64; i++) begin
      contMode = 0;
      step(0, 1, 0, 0, 0, 16'h0, "R7");
      if (i[0]) step(1, 0, 0, 0, 0, 16'h0, "R5");
      step(0, 0, 0, 1, 0, 16'(i * 37 + 5), "R2");
      step(0, 0, 0, 0, 1, 16'(i * 91 + 3), "R2");
      srcIsBus = i[1]; outputOn = i[2]; listenerAddr = i[3];
      step(0, i[4], i[5], 0, 0, 16'h0, "R3");
      idle("R4");
      step(0, 0, 1, 0, 0, 16'h0, "R5");
      idle("R5");
    end

    // R6: continuous mode rearms after each trigger
    srcIsBus = 1; outputOn = 1; listenerAddr = 1; contMode = 1;
    idle("R6");
    for (int k = 0; k < 6; k++) begin
      step(0, 0, 0, 1, 1, 16'(16'h4000 + k), "R2");
      step(0, 0, 1, 0, 0, 16'h0, "R6");
      step(0, 0, 1, 0, 0, 16'h0, "R6");
    end

    // R7: abort in continuous mode, rearm one cycle later
    step(0, 1, 0, 0, 0, 16'h0, "R7");
    step(0, 0, 1, 0, 0, 16'h0, "R7");
    step(0, 0, 1, 0, 0, 16'h0, "R7");
    step(1, 1, 0, 0, 0, 16'h0, "R7");

    // R8: arm and trigger together in single-shot mode
    contMode = 0;
    idle("R8");
    step(1, 0, 0, 0, 0, 16'h0, "R8");
    step(0, 0, 0, 1, 1, 16'h7777, "R8");
    step(1, 0, 1, 0, 0, 16'h0, "R8");
    idle("R8");

    // R9: write and trigger together applies the older value
    step(0, 0, 0, 1, 1, 16'h1111, "R9");
    step(0, 0, 1, 1, 1, 16'h2222, "R9");
    idle("R9");
    step(1, 0, 0, 0, 0, 16'h0, "R9");
    step(0, 0, 1, 0, 0, 16'h0, "R9");
    idle("R9");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule